// File: doc/BRIEF.md
# Dual-Compare Interval Timer with Buffered Reload

This block is a 16-bit up-counter that advances once for each cycle in which the timer is running and an external count tick is present. Two compare channels watch the counter, and each has its own interrupt pulse. A mode field picks what clears the counter: either a compare-1 match, or the counter wrapping past its all-ones value. The same field picks what drives the primary interrupt. Every interrupt is raised on the count tick that follows the matching value, so a compare value of N with clear-on-match gives a period of N+1 ticks.

Software never writes the active compare values directly. It writes byte-wide preset registers. While the timer runs, a preset moves into its active compare register only at the instant the counter clears, so a period already under way is never shortened or stretched. While the timer is stopped, the active registers follow the presets, so the first period after start uses the new values. The live counter cannot be read as two bytes without the risk of a carry tearing the value. For that reason, a write of any data to either capture address copies the whole counter into a capture register, and software reads that register byte by byte.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset the counter, both presets, both active compare values, the capture register and the mode field are all zero, and both interrupt outputs are low.
- R2: The counter rises by one at the end of every cycle in which `run` and `tick` are both high and no clear occurs. It holds its value in every other cycle.
- R3: The mode register holds bit 0 = clear on overflow and bit 1 = primary interrupt on overflow. The value 0 clears on compare-1. Any nonzero value clears on overflow. Reads at address 6 return the mode in bits 1:0 and zeros above them.
- R4: In modes 0 and 1, `irq_cmp1` is high for one clock following each count tick taken while the counter equals the active compare-1 value.
- R5: In modes 2 and 3, `irq_cmp1` is high for one clock following each count tick taken while the counter is 0xFFFF, and never in response to a compare-1 match.
- R6: A count tick that is also a clear event (per R3) sets the counter to 0x0000 instead of incrementing. A counter at 0xFFFF always wraps to 0x0000 on a tick.
- R7: `irq_cmp2` is high for one clock following each count tick taken while the counter equals the active compare-2 value, in every mode. A compare-2 match never clears the counter.
- R8: While running, each active compare value changes only when a clear occurs, and then takes the value its preset held before that clock edge.
- R9: While `run` is low, each active compare value takes its preset's value one clock later.
- R10: A write to address 4 or 5 with any data copies the counter value from before that edge into the capture register. Reads at 4 (low byte) and 5 (high byte) return it.
- R11: Addresses 0/1 hold the compare-1 preset low/high byte and addresses 2/3 the compare-2 preset low/high byte. Both are readable. Reads at address 7 return 0x00, and writes there have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run | input | 1 | Timer enable; low stops counting and makes actives follow presets |
| tick | input | 1 | Count-enable tick from an external prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data, combinational from rd_addr |
| irq_cmp1 | output | 1 | Primary interrupt pulse (compare-1 or overflow per mode) |
| irq_cmp2 | output | 1 | Compare-2 interrupt pulse |

## Verification
The assertions check the counter's step-or-hold rule, its return to zero after every clear, the rule that actives reload only on a clear or while stopped, the capture snapshot, and the rule that the primary interrupt only follows a tick. All of these are checked on every cycle. Whether an interrupt appears at the right tick for the selected mode, or a compare-2 match wrongly clears the counter, can only be seen in the bench. The bench compares both interrupt outputs against its own model on every cycle across mode changes, long overflow runs, preset rewrites in mid-period, and stop/start sequences.

// File: rtl/dct_pkg.sv
// Shared definitions for the dual-compare timer: register addresses and mode layout.
// Assumes an 8-bit register bus and a counter exactly two bus bytes wide.
package dct_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_P1_LO  = 3'd0,
        A_P1_HI  = 3'd1,
        A_P2_LO  = 3'd2,
        A_P2_HI  = 3'd3,
        A_CAP_LO = 3'd4,
        A_CAP_HI = 3'd5,
        A_MODE   = 3'd6,
        A_NONE   = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic irq_ovf;  // bit 1: primary interrupt from overflow
        logic clr_ovf;  // bit 0: counter clears on overflow
    } mode_t;
endpackage

// File: rtl/dct_regs.sv
// Register file: compare presets, mode field and capture register, plus the read mux.
// Assumes CNT_W == 2*BUS_W; capture writes ignore their data.
module dct_regs
    import dct_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int BUS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  pre1,
    output logic [CNT_W-1:0]  pre2,
    output logic [CNT_W-1:0]  cap,
    output logic              cap_wr,
    output mode_t             mode,
    output logic [BUS_W-1:0]  rd_data
);
    localparam int HI = CNT_W - 1;

    assign cap_wr = wr_en && (wr_addr == A_CAP_LO || wr_addr == A_CAP_HI);

    // Byte writes into presets and mode; snapshot of the counter on capture strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre1 <= '0;
            pre2 <= '0;
            cap  <= '0;
            mode <= '0;
        end else begin
            if (wr_en) begin
                case (wr_addr)
                    A_P1_LO: pre1[BUS_W-1:0]  <= wr_data;
                    A_P1_HI: pre1[HI:BUS_W]   <= wr_data;
                    A_P2_LO: pre2[BUS_W-1:0]  <= wr_data;
                    A_P2_HI: pre2[HI:BUS_W]   <= wr_data;
                    A_MODE:  mode             <= mode_t'(wr_data[1:0]);
                    default: ;
                endcase
            end
            if (cap_wr) cap <= cnt;
        end
    end

    // Combinational read mux.
    always_comb begin
        case (rd_addr)
            A_P1_LO:  rd_data = pre1[BUS_W-1:0];
            A_P1_HI:  rd_data = pre1[HI:BUS_W];
            A_P2_LO:  rd_data = pre2[BUS_W-1:0];
            A_P2_HI:  rd_data = pre2[HI:BUS_W];
            A_CAP_LO: rd_data = cap[BUS_W-1:0];
            A_CAP_HI: rd_data = cap[HI:BUS_W];
            A_MODE:   rd_data = {{(BUS_W-2){1'b0}}, mode};
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/dct_counter.sv
// Up-counter: steps on each enabled tick, returns to zero on a clear, wraps naturally.
// Assumes clr is only asserted together with tick_en.
module dct_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             at_max
);
    assign at_max = &cnt;

    // Clear has priority over increment.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (clr)     cnt <= '0;
        else if (tick_en) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dct_chan.sv
// One compare channel: active compare register reloaded from its preset, and a match flag.
// Assumes the preset is stable when the counter clears; reload also happens while stopped.
module dct_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [CNT_W-1:0] preset,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] active,
    output logic             hit
);
    assign hit = (cnt == active);

    // Double buffer: follow preset while stopped, otherwise only on a counter clear.
    always_ff @(posedge clk) begin
        if (!rst_n)           active <= '0;
        else if (!run || clr) active <= preset;
    end
endmodule

// File: rtl/dual_cmp_timer.sv
// Top level: two compare channels on a shared up-counter, mode-selected clear and primary
// interrupt sources, registered one-clock interrupt pulses. Assumes tick comes from a prescaler.
module dual_cmp_timer
    import dct_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int BUS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BUS_W-1:0]  rd_data,
    output logic              irq_cmp1,
    output logic              irq_cmp2
);
    localparam int NCH = 2;

    logic [CNT_W-1:0] cnt, pre1, pre2, cap, act1, act2;
    logic [CNT_W-1:0] pre_v [NCH];
    logic [CNT_W-1:0] act_v [NCH];
    logic [NCH-1:0]   hit_v;
    logic             cap_wr, at_max, tick_en, clr, ovf_ev, m1_ev, m2_ev, clr_on_ovf;
    mode_t            mode;

    dct_regs #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_regs (
        .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .cnt,
        .pre1, .pre2, .cap, .cap_wr, .mode, .rd_data
    );

    dct_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk, .rst_n, .tick_en, .clr, .cnt, .at_max
    );

    assign pre_v[0] = pre1;
    assign pre_v[1] = pre2;

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        dct_chan #(.CNT_W(CNT_W)) u_chan (
            .clk, .rst_n, .run, .clr, .preset(pre_v[i]), .cnt,
            .active(act_v[i]), .hit(hit_v[i])
        );
    end

    assign act1 = act_v[0];
    assign act2 = act_v[1];

    // Event decode: all events are qualified by an enabled tick.
    assign tick_en    = run & tick;
    assign clr_on_ovf = mode.clr_ovf | mode.irq_ovf;
    assign ovf_ev     = tick_en & at_max;
    assign m1_ev      = tick_en & hit_v[0];
    assign m2_ev      = tick_en & hit_v[1];
    assign clr        = clr_on_ovf ? ovf_ev : m1_ev;

    // Interrupt pulses registered one clock after the qualifying tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_cmp1 <= 1'b0;
            irq_cmp2 <= 1'b0;
        end else begin
            irq_cmp1 <= mode.irq_ovf ? ovf_ev : m1_ev;
            irq_cmp2 <= m2_ev;
        end
    end
endmodule

// File: rtl/dct_checker.sv
// Property checker for dual_cmp_timer, bound to every instance of the top.
module dct_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             tick_en,
    input logic             clr,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] act1,
    input logic [CNT_W-1:0] pre1,
    input logic [CNT_W-1:0] cap,
    input logic             cap_wr,
    input logic             irq1
);
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en && !clr |=> cnt == $past(cnt) + 1'b1);
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(cnt));
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == '0);
    a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> act1 == $past(pre1));
    a_r8_keep: assert property (@(posedge clk) disable iff (!rst_n)
        run && !clr |=> $stable(act1));
    a_r9_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> act1 == $past(pre1));
    a_r10_snap: assert property (@(posedge clk) disable iff (!rst_n)
        cap_wr |=> cap == $past(cnt));
    a_r4_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        irq1 |-> $past(tick_en));
endmodule

bind dual_cmp_timer dct_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .tick_en(tick_en), .clr(clr), .cnt(cnt),
    .act1(act1), .pre1(pre1), .cap(cap), .cap_wr(cap_wr), .irq1(irq_cmp1)
);

// File: tb/dual_cmp_timer_bench.sv
`timescale 1ns/1ps
module dual_cmp_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0, tick = 1'b0, wr_en = 1'b0;
    logic [2:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq_cmp1, irq_cmp2;
    int         n_run = 0, n_fail = 0;
    bit         chk_on = 1'b0;

    always #2.5 clk = ~clk;

    dual_cmp_timer u_dual_cmp_timer (
        .clk, .rst_n, .run, .tick, .wr_en, .wr_addr, .wr_data, .rd_addr,
        .rd_data, .irq_cmp1, .irq_cmp2
    );

    // Reference model built from the requirements.
    logic [15:0] m_cnt, m_p1, m_p2, m_a1, m_a2, m_cap;
    logic [1:0]  m_mode;
    logic        m_irq1, m_irq2;

    always @(posedge clk) begin
        logic te, ovf, h1, h2, clr;
        if (!rst_n) begin
            m_cnt <= 0; m_p1 <= 0; m_p2 <= 0; m_a1 <= 0; m_a2 <= 0; m_cap <= 0;
            m_mode <= 0; m_irq1 <= 0; m_irq2 <= 0;
        end else begin
            te  = run && tick;
            ovf = te && (m_cnt == 16'hFFFF);
            h1  = te && (m_cnt == m_a1);
            h2  = te && (m_cnt == m_a2);
            clr = (m_mode != 2'd0) ? ovf : h1;
            m_irq1 <= m_mode[1] ? ovf : h1;
            m_irq2 <= h2;
            m_cnt  <= clr ? 16'h0 : (te ? m_cnt + 16'd1 : m_cnt);
            if (!run || clr) begin m_a1 <= m_p1; m_a2 <= m_p2; end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_p1[7:0]  <= wr_data;
                    3'd1: m_p1[15:8] <= wr_data;
                    3'd2: m_p2[7:0]  <= wr_data;
                    3'd3: m_p2[15:8] <= wr_data;
                    3'd4, 3'd5: m_cap <= m_cnt;
                    3'd6: m_mode <= wr_data[1:0];
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [7:0] model_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_p1[7:0];
            3'd1: return m_p1[15:8];
            3'd2: return m_p2[7:0];
            3'd3: return m_p2[15:8];
            3'd4: return m_cap[7:0];
            3'd5: return m_cap[15:8];
            3'd6: return {6'd0, m_mode};
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-cycle interrupt comparison: R4/R5 on the primary, R7 on compare-2.
    always @(negedge clk) begin
        if (rst_n && chk_on) begin
            check(m_mode[1] ? "R5 irq_cmp1" : "R4 irq_cmp1", {15'd0, irq_cmp1}, {15'd0, m_irq1});
            check("R7 irq_cmp2", {15'd0, irq_cmp2}, {15'd0, m_irq2});
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a);
        @(negedge clk); rd_addr = a; #1;
        check(req, {8'd0, rd_data}, {8'd0, model_rd(a)});
    endtask

    task automatic snap_chk(input string req);
        wr(3'd4, 8'hA5);
        rd_chk(req, 3'd4);
        rd_chk(req, 3'd5);
    endtask

    task automatic wr16(input logic [2:0] base, input logic [15:0] v);
        wr(base, v[7:0]);
        wr(base + 3'd1, v[15:8]);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        cycles(3);
        #1;
        check("R1 irq_cmp1 in reset", {15'd0, irq_cmp1}, 16'd0);
        rst_n = 1'b1;
        cycles(1);
        chk_on = 1'b1;
        // R1 reset state and R11 empty address
        for (int a = 0; a < 8; a++) begin
            @(negedge clk); rd_addr = 3'(a); #1;
            check(a == 7 ? "R11 unused address" : "R1 reset value", {8'd0, rd_data}, 16'd0);
        end
        // R9: presets copied while stopped
        wr16(3'd0, 16'd4);
        wr16(3'd2, 16'd2);
        rd_chk("R11 preset1 low byte", 3'd0);
        rd_chk("R11 preset2 low byte", 3'd2);
        wr(3'd7, 8'hFF);
        rd_chk("R11 write to unused address", 3'd7);
        @(negedge clk); run = 1'b1; tick = 1'b1;
        cycles(23);
        snap_chk("R9 R6 count after first periods");
        // R2: hold while ticks absent and while stopped
        @(negedge clk); tick = 1'b0;
        cycles(5);
        snap_chk("R2 hold without tick");
        @(negedge clk); run = 1'b0; tick = 1'b1;
        cycles(4);
        snap_chk("R2 hold while stopped");
        // R8: preset rewrite mid-period keeps current period
        wr16(3'd0, 16'd40);
        @(negedge clk); run = 1'b1;
        cycles(12);
        wr16(3'd0, 16'd3);
        cycles(10);
        snap_chk("R8 period kept after preset rewrite");
        cycles(40);
        snap_chk("R8 new period after clear");
        // R7: compare-2 independent, no clear
        wr16(3'd0, 16'd10);
        wr16(3'd2, 16'd7);
        cycles(35);
        snap_chk("R7 count unaffected by compare-2");
        // R3 + R4: mode 1, compare-1 irq without clear, full wrap
        wr(3'd6, 8'hFD);
        rd_chk("R3 mode readback", 3'd6);
        wr16(3'd0, 16'd100);
        cycles(300);
        snap_chk("R3 no clear at compare-1 in mode 1");
        cycles(65400);
        snap_chk("R6 wrap after overflow");
        // R5: mode 2, overflow drives primary interrupt
        wr(3'd6, 8'h02);
        rd_chk("R3 mode 2 readback", 3'd6);
        cycles(65600);
        snap_chk("R5 count after overflow in mode 2");
        // Random mix
        void'($urandom(32'h1234_5678));
        wr(3'd6, 8'h00);
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            @(negedge clk);
            tick = ($urandom_range(0, 3) != 0);
            if (r < 3) run = ~run;
            else if (r < 8) begin
                wr_en = 1'b1; wr_addr = 3'($urandom_range(0, 3));
                wr_data = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'($urandom_range(0, 30));
                if (wr_addr[0]) wr_data = 8'h00;
                @(negedge clk); wr_en = 1'b0;
            end else if (r < 9) begin
                wr(3'd6, 8'($urandom_range(0, 3)));
            end else if (r < 11) begin
                snap_chk("R10 random capture");
            end
        end
        run = 1'b1;
        snap_chk("R10 final capture");
        chk_on = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule